// File: doc/BRIEF.md
# Multiplexed Latching Bus Exchanger

This block connects one narrow data port, A, to two wide-side ports, B1 and B2, each the same width as A. Words travelling from A outward pass through two separate storage banks, one per wide-side port. Each bank has its own enable, so B1 and B2 can capture different A words at different times. This lets two successive words on A be split across the two ports, as in address and data demultiplexing or memory interleaving.

Words travelling back toward A pass through a second pair of storage latches, one fed by B1 and one fed by B2. A select input picks which of the two reaches A. Every latch is level-sensitive. It passes its input straight through while its enable is high, keeps the value present when the enable falls, and holds that value for as long as the enable stays low.

Each port is modelled as three signals: an input vector, an output vector, and one drive bit that stands in for a pad's output enable. The drive bit of a port is set exactly when that port's active-low enable input is low. The output vectors carry the latch or multiplexer result whether or not the drive bit is set.

Top module: `mux_latch_exchanger`

## Requirements
- R1: While `le_ab1` is high, `b1_dout` equals `a_din` and follows every change of it.
- R2: When `le_ab1` falls, `b1_dout` keeps the `a_din` value from just before the fall, and ignores later changes of `a_din` while `le_ab1` stays low.
- R3: The B2-bound bank, controlled by `le_ab2`, is transparent while `le_ab2` is high and holds its value while it is low. It works independently of `le_ab1`, so `b2_dout` can hold one A word while `b1_dout` holds another.
- R4: The return latches, controlled by `le_ba1` (fed from `b1_din`) and `le_ba2` (fed from `b2_din`), are transparent while their enable is high and hold the value present at the falling edge while it is low.
- R5: `a_dout` shows the B1-fed return latch when `sel_b1` is 1, and the B2-fed return latch when `sel_b1` is 0. A change of `sel_b1` alone switches `a_dout` between two held values.
- R6: `a_drive` is 1 exactly when `a_en_n` is 0.
- R7: `b1_drive` and `b2_drive` are 1 exactly when `b1_en_n` and `b2_en_n` are 0, respectively. All four combinations of the two enables are accepted.
- R8: The enable inputs change only the drive bits. The data outputs and the stored values are unaffected by them.
- R9: The port width is set by parameter `W`, which defaults to 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_din | input | W | Word arriving on port A |
| a_dout | output | W | Word presented on port A (selected return latch) |
| a_drive | output | 1 | Port A pad drive enable |
| b1_din | input | W | Word arriving on port B1 |
| b1_dout | output | W | Word presented on port B1 |
| b1_drive | output | 1 | Port B1 pad drive enable |
| b2_din | input | W | Word arriving on port B2 |
| b2_dout | output | W | Word presented on port B2 |
| b2_drive | output | 1 | Port B2 pad drive enable |
| le_ab1 | input | 1 | Enable of the A-to-B1 storage bank, high = transparent |
| le_ab2 | input | 1 | Enable of the A-to-B2 storage bank, high = transparent |
| le_ba1 | input | 1 | Enable of the B1-fed return latch, high = transparent |
| le_ba2 | input | 1 | Enable of the B2-fed return latch, high = transparent |
| sel_b1 | input | 1 | Return source select: 1 = B1 path, 0 = B2 path |
| a_en_n | input | 1 | Active-low output enable of port A |
| b1_en_n | input | 1 | Active-low output enable of port B1 |
| b2_en_n | input | 1 | Active-low output enable of port B2 |

## Verification
The assertions cover the relations that hold at every settled instant. Each open latch must pass its input through, each drive bit must be the inverse of its enable, and an open return latch must reach A whenever the select points at it. Holding behaviour cannot be expressed this way. That includes capture at the falling edge, bank independence when one bank holds an older word, switching the select between two held words, and data outputs staying put while the enables toggle. Only the bench's sequences, which change data after the enables have closed, can show these.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned XCHG_W_DEF = 12;
  localparam int unsigned XCHG_NPORT = 3;

  typedef enum logic {
    SRC_B2 = 1'b0,
    SRC_B1 = 1'b1
  } ret_src_e;

  function automatic logic drive_of(input logic en_n);
    return ~en_n;
  endfunction
endpackage

// File: rtl/xchg_latch.sv
module xchg_latch #(
  parameter int unsigned W = 12
) (
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (open_i) q_o <= d_i;
  end
endmodule

// File: rtl/xchg_retmux.sv
module xchg_retmux
  import xchg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         sel_i,
  input  logic [W-1:0] from_b1_i,
  input  logic [W-1:0] from_b2_i,
  output logic [W-1:0] y_o
);
  ret_src_e src;
  assign src = ret_src_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_B1:  y_o = from_b1_i;
      default: y_o = from_b2_i;
    endcase
  end
endmodule

// File: rtl/xchg_port_en.sv
module xchg_port_en
  import xchg_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] en_n_i,
  output logic [N-1:0] drive_o
);
  for (genvar g = 0; g < N; g++) begin : g_port
    assign drive_o[g] = drive_of(en_n_i[g]);
  end
endmodule

// File: rtl/mux_latch_exchanger.sv
module mux_latch_exchanger
  import xchg_pkg::*;
#(
  parameter int unsigned W = XCHG_W_DEF
) (
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_drive,
  input  logic [W-1:0] b1_din,
  output logic [W-1:0] b1_dout,
  output logic         b1_drive,
  input  logic [W-1:0] b2_din,
  output logic [W-1:0] b2_dout,
  output logic         b2_drive,
  input  logic         le_ab1,
  input  logic         le_ab2,
  input  logic         le_ba1,
  input  logic         le_ba2,
  input  logic         sel_b1,
  input  logic         a_en_n,
  input  logic         b1_en_n,
  input  logic         b2_en_n
);
  localparam int unsigned NPORT = XCHG_NPORT;

  // Named internal events for the assertions
  logic [W-1:0]     ret_b1_q;
  logic [W-1:0]     ret_b2_q;
  logic [NPORT-1:0] en_n_vec;
  logic [NPORT-1:0] drive_vec;

  // Outbound banks (A to B1, A to B2)
  xchg_latch #(.W(W)) u_ab1 (.open_i(le_ab1), .d_i(a_din), .q_o(b1_dout));
  xchg_latch #(.W(W)) u_ab2 (.open_i(le_ab2), .d_i(a_din), .q_o(b2_dout));

  // Return latches (B1 to A, B2 to A)
  xchg_latch #(.W(W)) u_ba1 (.open_i(le_ba1), .d_i(b1_din), .q_o(ret_b1_q));
  xchg_latch #(.W(W)) u_ba2 (.open_i(le_ba2), .d_i(b2_din), .q_o(ret_b2_q));

  xchg_retmux #(.W(W)) u_mux (
    .sel_i     (sel_b1),
    .from_b1_i (ret_b1_q),
    .from_b2_i (ret_b2_q),
    .y_o       (a_dout)
  );

  assign en_n_vec = {b2_en_n, b1_en_n, a_en_n};

  xchg_port_en #(.N(NPORT)) u_en (.en_n_i(en_n_vec), .drive_o(drive_vec));

  assign a_drive  = drive_vec[0];
  assign b1_drive = drive_vec[1];
  assign b2_drive = drive_vec[2];

  // Assertions
  always_comb begin
    if (le_ab1) begin
      a_r1_ab1_transparent: assert (b1_dout == a_din);
    end
    if (le_ab2) begin
      a_r3_ab2_transparent: assert (b2_dout == a_din);
    end
    if (le_ba1 && sel_b1) begin
      a_r5_sel_b1_path: assert (a_dout == b1_din);
    end
    if (le_ba2 && !sel_b1) begin
      a_r5_sel_b2_path: assert (a_dout == b2_din);
    end
    a_r6_a_drive: assert (a_drive == !a_en_n);
    a_r7_b_drive: assert ((b1_drive == !b1_en_n) && (b2_drive == !b2_en_n));
  end
endmodule

// File: tb/test_mux_latch_exchanger.sv
module test_mux_latch_exchanger;
  localparam int W = 12;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b1;
    logic [W-1:0] b2;
    logic [3:0]   le;    // {ab1, ab2, ba1, ba2}
    logic         sel;
    logic [2:0]   en_n;  // {a, b1, b2}
    logic [W-1:0] ea;
    logic [W-1:0] eb1;
    logic [W-1:0] eb2;
  } step_t;

  localparam int NSTEP = 9;
  localparam step_t STEPS [NSTEP] = '{
    '{12'h111, 12'h222, 12'h333, 4'b1111, 1'b1, 3'b000, 12'h222, 12'h111, 12'h111},
    '{12'h444, 12'h555, 12'h666, 4'b1010, 1'b0, 3'b000, 12'h333, 12'h444, 12'h111},
    '{12'h777, 12'h888, 12'h999, 4'b0101, 1'b1, 3'b000, 12'h555, 12'h444, 12'h777},
    '{12'h777, 12'h888, 12'h999, 4'b0101, 1'b0, 3'b000, 12'h999, 12'h444, 12'h777},
    '{12'hAAA, 12'hBBB, 12'hCCC, 4'b0000, 1'b0, 3'b000, 12'h999, 12'h444, 12'h777},
    '{12'hAAA, 12'hBBB, 12'hCCC, 4'b0000, 1'b1, 3'b000, 12'h555, 12'h444, 12'h777},
    '{12'hAAA, 12'hBBB, 12'hCCC, 4'b0000, 1'b1, 3'b101, 12'h555, 12'h444, 12'h777},
    '{12'hAAA, 12'hBBB, 12'hCCC, 4'b0000, 1'b1, 3'b010, 12'h555, 12'h444, 12'h777},
    '{12'hAAA, 12'hBBB, 12'hCCC, 4'b0000, 1'b1, 3'b111, 12'h555, 12'h444, 12'h777}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a_din = '0, b1_din = '0, b2_din = '0;
  logic [W-1:0] a_dout, b1_dout, b2_dout;
  logic a_drive, b1_drive, b2_drive;
  logic le_ab1 = 1'b1, le_ab2 = 1'b1, le_ba1 = 1'b1, le_ba2 = 1'b1;
  logic sel_b1 = 1'b1;
  logic a_en_n = 1'b1, b1_en_n = 1'b1, b2_en_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  mux_latch_exchanger #(.W(W)) i_mux_latch_exchanger (
    .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
    .b1_din(b1_din), .b1_dout(b1_dout), .b1_drive(b1_drive),
    .b2_din(b2_din), .b2_dout(b2_dout), .b2_drive(b2_drive),
    .le_ab1(le_ab1), .le_ab2(le_ab2), .le_ba1(le_ba1), .le_ba2(le_ba2),
    .sel_b1(sel_b1), .a_en_n(a_en_n), .b1_en_n(b1_en_n), .b2_en_n(b2_en_n)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Controls move first, data moves afterwards, so a closing latch keeps old data.
  task automatic apply(input step_t s);
    @(negedge clk);
    {le_ab1, le_ab2, le_ba1, le_ba2} = s.le;
    sel_b1 = s.sel;
    {a_en_n, b1_en_n, b2_en_n} = s.en_n;
    #3;
    a_din = s.a; b1_din = s.b1; b2_din = s.b2;
    #3;
  endtask

  initial begin
    // Starting state: all latches open, all enables high (no port driven)
    #5;
    check("R6", "a_drive idle", W'(a_drive), W'(0));
    check("R7", "b1_drive idle", W'(b1_drive), W'(0));
    check("R7", "b2_drive idle", W'(b2_drive), W'(0));
    check("R9", "width", W'($bits(a_dout)), W'(12));

    for (int i = 0; i < NSTEP; i++) begin
      apply(STEPS[i]);
      check("R4,R5", $sformatf("step %0d a_dout", i), a_dout, STEPS[i].ea);
      check("R1,R2,R8", $sformatf("step %0d b1_dout", i), b1_dout, STEPS[i].eb1);
      check("R3,R8", $sformatf("step %0d b2_dout", i), b2_dout, STEPS[i].eb2);
      check("R6", $sformatf("step %0d a_drive", i), W'(a_drive), W'(!STEPS[i].en_n[2]));
      check("R7", $sformatf("step %0d b1_drive", i), W'(b1_drive), W'(!STEPS[i].en_n[1]));
      check("R7", $sformatf("step %0d b2_drive", i), W'(b2_drive), W'(!STEPS[i].en_n[0]));
    end

    // R1: open B1 bank follows a sequence of A words; B2 bank (closed) holds 777 (R3)
    @(negedge clk);
    le_ab1 = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #3 a_din = W'(12'h0F0 + k * 12'h101);
      #3 check("R1", "b1 follows a", b1_dout, W'(12'h0F0 + k * 12'h101));
      check("R3", "b2 independent hold", b2_dout, W'(12'h777));
    end
    // R2: close, then change A; B1 keeps last word 0x3F3
    @(negedge clk);
    le_ab1 = 1'b0;
    #3 a_din = 12'h5A5;
    #3 check("R2", "b1 hold after close", b1_dout, W'(12'h3F3));

    // R4: B1 return latch captures 0x123, then ignores new B1 input
    @(negedge clk);
    sel_b1 = 1'b1; le_ba1 = 1'b1;
    #3 b1_din = 12'h123;
    #3 check("R4", "return open", a_dout, W'(12'h123));
    le_ba1 = 1'b0;
    #3 b1_din = 12'hFED;
    #3 check("R4", "return hold", a_dout, W'(12'h123));
    // R5: select flip between two held values (B2 path holds 0x999)
    sel_b1 = 1'b0;
    #3 check("R5", "sel to b2 held", a_dout, W'(12'h999));

    // R8: toggling all enables leaves data outputs unchanged
    {a_en_n, b1_en_n, b2_en_n} = 3'b000;
    #3 {a_en_n, b1_en_n, b2_en_n} = 3'b110;
    #3 check("R8", "a_dout under enable toggle", a_dout, W'(12'h999));
    check("R8", "b1_dout under enable toggle", b1_dout, W'(12'h3F3));
    check("R8", "b2_dout under enable toggle", b2_dout, W'(12'h777));
    check("R7", "b2 alone driven", W'({b1_drive, b2_drive}), W'(2'b01));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule